// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical address through a small on-chip table of segments. The upper bits of the virtual address select one table entry. The lower bits are an offset into that segment. Each entry holds a physical base address, a segment length and three permission bits. An accepted request gives one of two results. The first is a physical address, which is the entry's base plus the offset. The second is an exception cause code, which a handler outside the block acts on.

Privileged software loads the table through a dedicated write port. Two entries may describe the same physical region with different rights. One process can then read a shared segment while another may also write it. If a write reaches an entry whose write right is clear, the block raises a protection trap. Software can use that trap to copy a shared segment on demand. Requests and responses each use a valid/ready handshake. The result appears one cycle after acceptance and is held while the consumer stalls.

Top module: `seg_xlate_top`

## Requirements
- R1: The virtual address is 16 bits wide. Bits 15:14 select the segment (entries 0 to 3) and bits 13:0 are the offset.
- R2: When `tw_en` is high at a clock edge, entry `tw_idx` takes `tw_base`, `tw_len` (15 bits, so a full 16384-byte segment can be described) and `tw_perm`. The permission bits are: bit 0 read allowed, bit 1 write allowed, bit 2 entry valid.
- R3: A permitted, in-range access returns cause 0 and a physical address equal to base plus the zero-extended offset, modulo 2^32. Any non-zero cause returns a physical address of 0.
- R4: An offset greater than or equal to the entry length returns cause 1 (bound violation).
- R5: A write to an entry whose write bit is clear returns cause 2 (protection). So does a read of an entry whose read bit is clear.
- R6: Any access to an entry whose valid bit is clear returns cause 3 (invalid segment).
- R7: When several faults apply, the cause is chosen in this order: invalid segment, then protection, then bound.
- R8: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Its response is presented on `resp_valid` from that edge onward.
- R9: While `resp_valid` is high and `resp_ready` is low, the response stays unchanged and `req_ready` is low. While `resp_valid` is low, `req_ready` is high.
- R10: A table write at the same edge as an accepted request does not affect that request. It does affect requests accepted from the next edge onward.
- R11: After a synchronous active-low reset, `resp_valid` is low and all four entries are invalid.
- R12: Two entries with the same base and length but different permissions give independent results for the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 16 | Virtual address: segment in 15:14, offset in 13:0 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 2 | Entry to write |
| tw_base | input | 32 | Physical base of the segment |
| tw_len | input | 15 | Segment length in bytes |
| tw_perm | input | 3 | Bit 0 read, bit 1 write, bit 2 valid |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_paddr | output | 32 | Physical address (0 on a fault) |
| resp_cause | output | 2 | 0 none, 1 bound, 2 protection, 3 invalid |

## Verification
Some properties hold on every cycle and are checked by assertions there. A stalled response is held stable. `req_ready` follows the response stage. Every accepted request produces a response on the next cycle. A faulting response never carries a non-zero address. The bench covers what depends on table contents. This includes the sum of base and offset with wrap-around, the bound check at its exact limit, the order in which causes win, and sharing between two entries with different rights. It also covers a table write landing in the same cycle as a request. A behavioural model is compared against the outputs on every clock during directed scenarios and a randomized run with random backpressure.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the segment translator.
// Assumes: two-bit cause code and three permission bits with fixed positions.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_BOUND   = 2'd1,
        CAUSE_PROT    = 2'd2,
        CAUSE_INVALID = 2'd3
    } cause_t;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_VLD = 2;
endpackage

// File: rtl/seg_table.sv
`timescale 1ns/1ps
// Segment descriptor storage: one write port and one asynchronous read port.
// Assumes: writes land at the clock edge, so a read in the same cycle sees old contents.
module seg_table #(
    parameter int SEG_W = 2,
    parameter int LEN_W = 15,
    parameter int PA_W  = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SEG_W-1:0]                   wr_idx,
    input  logic [PA_W-1:0]                    wr_base,
    input  logic [LEN_W-1:0]                   wr_len,
    input  logic [seg_xlate_pkg::PERM_W-1:0]   wr_perm,
    input  logic [SEG_W-1:0]                   rd_idx,
    output logic [PA_W-1:0]                    rd_base,
    output logic [LEN_W-1:0]                   rd_len,
    output logic [seg_xlate_pkg::PERM_W-1:0]   rd_perm
);
    localparam int NSEG = 1 << SEG_W;

    logic [PA_W-1:0]                  base_q [NSEG];
    logic [LEN_W-1:0]                 len_q  [NSEG];
    logic [seg_xlate_pkg::PERM_W-1:0] perm_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        // Hold one descriptor; cleared to invalid on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                len_q[g]  <= '0;
                perm_q[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                base_q[g] <= wr_base;
                len_q[g]  <= wr_len;
                perm_q[g] <= wr_perm;
            end
        end
    end

    // Select the descriptor addressed by the current request.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_len  = len_q[rd_idx];
        rd_perm = perm_q[rd_idx];
    end
endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
// Combinational checker and adder: rates one access against one descriptor.
// Assumes: PA_W exceeds OFF_W; the cause order is invalid, then protection, then bound.
module seg_check #(
    parameter int OFF_W = 14,
    parameter int PA_W  = 32
) (
    input  logic [OFF_W-1:0]                 offset,
    input  logic                             is_write,
    input  logic [PA_W-1:0]                  base,
    input  logic [OFF_W:0]                   len,
    input  logic [seg_xlate_pkg::PERM_W-1:0] perm,
    output seg_xlate_pkg::cause_t            cause,
    output logic [PA_W-1:0]                  paddr
);
    import seg_xlate_pkg::*;

    logic right_ok;
    logic in_range;

    // Work out the access right and the range test separately.
    always_comb begin
        right_ok = is_write ? perm[PERM_WR] : perm[PERM_RD];
        in_range = {1'b0, offset} < len;
    end

    // Pick the winning cause and form the address only when there is no fault.
    always_comb begin
        paddr = '0;
        if (!perm[PERM_VLD]) begin
            cause = CAUSE_INVALID;
        end else if (!right_ok) begin
            cause = CAUSE_PROT;
        end else if (!in_range) begin
            cause = CAUSE_BOUND;
        end else begin
            cause = CAUSE_NONE;
            paddr = base + {{(PA_W-OFF_W){1'b0}}, offset};
        end
    end
endmodule

// File: rtl/seg_resp_stage.sv
`timescale 1ns/1ps
// One-entry response register with valid/ready flow control.
// Assumes: the upstream result is combinational and valid in the cycle of acceptance.
module seg_resp_stage #(
    parameter int PA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PA_W-1:0]       in_paddr,
    input  seg_xlate_pkg::cause_t in_cause,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PA_W-1:0]       out_paddr,
    output seg_xlate_pkg::cause_t out_cause
);
    // Accept new work when the register is empty or being emptied.
    always_comb in_ready = !out_valid || out_ready;

    // Load on acceptance, drop when consumed, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_cause <= seg_xlate_pkg::CAUSE_NONE;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_paddr <= in_paddr;
            out_cause <= in_cause;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/seg_xlate_top.sv
`timescale 1ns/1ps
// Segment-table translator top: splits the virtual address, reads the table,
// checks the access and registers the result behind a valid/ready handshake.
// Assumes: synchronous active-low reset; the segment field sits above the offset.
module seg_xlate_top #(
    parameter int SEG_W = 2,
    parameter int OFF_W = 14,
    parameter int PA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [SEG_W+OFF_W-1:0] req_vaddr,
    input  logic                   req_write,
    input  logic                   tw_en,
    input  logic [SEG_W-1:0]       tw_idx,
    input  logic [PA_W-1:0]        tw_base,
    input  logic [OFF_W:0]         tw_len,
    input  logic [2:0]             tw_perm,
    output logic                   resp_valid,
    input  logic                   resp_ready,
    output logic [PA_W-1:0]        resp_paddr,
    output logic [1:0]             resp_cause
);
    import seg_xlate_pkg::*;

    localparam int VA_W  = SEG_W + OFF_W;
    localparam int LEN_W = OFF_W + 1;

    logic [SEG_W-1:0]  seg_idx;
    logic [OFF_W-1:0]  seg_off;
    logic [PA_W-1:0]   ent_base;
    logic [LEN_W-1:0]  ent_len;
    logic [PERM_W-1:0] ent_perm;
    cause_t            chk_cause;
    logic [PA_W-1:0]   chk_paddr;
    cause_t            out_cause;

    // Split the virtual address into its segment and offset fields.
    always_comb begin
        seg_idx = req_vaddr[VA_W-1:OFF_W];
        seg_off = req_vaddr[OFF_W-1:0];
    end

    seg_table #(.SEG_W(SEG_W), .LEN_W(LEN_W), .PA_W(PA_W)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tw_en),
        .wr_idx  (tw_idx),
        .wr_base (tw_base),
        .wr_len  (tw_len),
        .wr_perm (tw_perm),
        .rd_idx  (seg_idx),
        .rd_base (ent_base),
        .rd_len  (ent_len),
        .rd_perm (ent_perm)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) i_check (
        .offset   (seg_off),
        .is_write (req_write),
        .base     (ent_base),
        .len      (ent_len),
        .perm     (ent_perm),
        .cause    (chk_cause),
        .paddr    (chk_paddr)
    );

    seg_resp_stage #(.PA_W(PA_W)) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_paddr  (chk_paddr),
        .in_cause  (chk_cause),
        .out_valid (resp_valid),
        .out_ready (resp_ready),
        .out_paddr (resp_paddr),
        .out_cause (out_cause)
    );

    // Present the cause as a plain two-bit code.
    always_comb resp_cause = out_cause;
endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
// Protocol checker for the translator ports; attached by bind below.
// Assumes: synchronous active-low reset shared with the design.
module seg_xlate_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            resp_valid,
    input logic            resp_ready,
    input logic [PA_W-1:0] resp_paddr,
    input logic [1:0]      resp_cause
);
    // R9: a stalled response keeps its contents.
    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) && $stable(resp_cause)));

    // R9: no new request is taken while the response is blocked.
    assert_block_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |-> !req_ready);

    // R9: an empty response stage is always ready.
    assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> req_ready);

    // R8: every accepted request yields a response on the next cycle.
    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    // R3: a faulting response carries no address.
    assert_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cause != 2'd0) |-> resp_paddr == '0);
endmodule

bind seg_xlate_top seg_xlate_chk #(.PA_W(PA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_paddr (resp_paddr),
    .resp_cause (resp_cause)
);

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
// Bench: behavioural model compared on every clock plus directed scenarios.
module test_seg_xlate_top;
    localparam int SEG_W = 2;
    localparam int OFF_W = 14;
    localparam int PA_W  = 32;
    localparam int NSEG  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1, tw_en = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  tw_idx = '0;
    logic [31:0] tw_base = '0;
    logic [14:0] tw_len = '0;
    logic [2:0]  tw_perm = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_cause;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit cmp_on   = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate_top #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .tw_en(tw_en), .tw_idx(tw_idx),
        .tw_base(tw_base), .tw_len(tw_len), .tw_perm(tw_perm), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_paddr(resp_paddr), .resp_cause(resp_cause)
    );

    // Reference model state.
    logic [31:0] m_base [NSEG];
    logic [14:0] m_len  [NSEG];
    logic [2:0]  m_perm [NSEG];
    logic        m_rv = 1'b0;
    logic [31:0] m_pa = '0;
    logic [1:0]  m_cause = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each edge: answer with the old table, then apply any write.
    always @(posedge clk) begin
        cycles++;
        cmp_on = 1'b1;
        if (!rst_n) begin
            m_rv = 1'b0; m_pa = '0; m_cause = '0;
            for (int i = 0; i < NSEG; i++) begin
                m_base[i] = '0; m_len[i] = '0; m_perm[i] = '0;
            end
        end else begin
            if (req_valid && (!m_rv || resp_ready)) begin
                int s;
                int o;
                bit ok;
                s = int'(req_vaddr[15:14]);
                o = int'(req_vaddr[13:0]);
                ok = req_write ? m_perm[s][1] : m_perm[s][0];
                m_rv = 1'b1;
                m_pa = '0;
                if (!m_perm[s][2])            m_cause = 2'd3;
                else if (!ok)                 m_cause = 2'd2;
                else if (o >= int'(m_len[s])) m_cause = 2'd1;
                else begin
                    m_cause = 2'd0;
                    m_pa = m_base[s] + 32'(o);
                end
            end else if (resp_ready) begin
                m_rv = 1'b0;
            end
            if (tw_en) begin
                m_base[tw_idx] = tw_base;
                m_len[tw_idx]  = tw_len;
                m_perm[tw_idx] = tw_perm;
            end
        end
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R8/R11 resp_valid", 32'(resp_valid), 32'(m_rv));
            check("R9 req_ready", 32'(req_ready), 32'(!m_rv || resp_ready));
            if (m_rv) begin
                case (m_cause)
                    2'd0: check("R3 paddr", resp_paddr, m_pa);
                    2'd1: check("R4 paddr", resp_paddr, m_pa);
                    2'd2: check("R5 paddr", resp_paddr, m_pa);
                    default: check("R6 paddr", resp_paddr, m_pa);
                endcase
                check("R7 cause", 32'(resp_cause), 32'(m_cause));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic twr(int idx, logic [31:0] b, logic [14:0] l, logic [2:0] p);
        tw_en = 1'b1; tw_idx = 2'(idx); tw_base = b; tw_len = l; tw_perm = p;
        step();
        tw_en = 1'b0;
    endtask

    // Issue one request with resp_ready high and check the response.
    task automatic xreq(string tag, int seg, int off, bit wr, logic [1:0] ec, logic [31:0] ep);
        req_valid = 1'b1; req_vaddr = {2'(seg), 14'(off)}; req_write = wr;
        step();
        req_valid = 1'b0;
        @(negedge clk);
        check({tag, " valid"}, 32'(resp_valid), 32'd1);
        check({tag, " cause"}, 32'(resp_cause), 32'(ec));
        check({tag, " paddr"}, resp_paddr, ep);
        step();
    endtask

    initial begin
        #1;
        repeat (3) step();
        @(negedge clk);
        check("R11 reset resp_valid", 32'(resp_valid), 32'd0);
        step();
        rst_n = 1'b1;
        step();
        // R11: entries invalid after reset.
        xreq("R11 invalid after reset", 0, 5, 1'b0, 2'd3, 32'h0);

        // R2: load the table. Perm bits: 0 read, 1 write, 2 valid.
        twr(0, 32'h1000_0000, 15'h4000, 3'b111);
        twr(1, 32'h2000_0000, 15'h0100, 3'b101);
        twr(2, 32'h2000_0000, 15'h0100, 3'b111);
        twr(3, 32'hFFFF_FFF0, 15'h0000, 3'b011);

        xreq("R1 top offset seg0", 0, 16'h3FFF, 1'b0, 2'd0, 32'h1000_3FFF);
        xreq("R3 base plus offset", 0, 16'h0123, 1'b1, 2'd0, 32'h1000_0123);
        xreq("R4 last in range", 1, 16'h00FF, 1'b0, 2'd0, 32'h2000_00FF);
        xreq("R4 bound at length", 1, 16'h0100, 1'b0, 2'd1, 32'h0);
        xreq("R5 write read-only", 1, 16'h0010, 1'b1, 2'd2, 32'h0);
        xreq("R12 shared writable", 2, 16'h0010, 1'b1, 2'd0, 32'h2000_0010);
        xreq("R7 prot beats bound", 1, 16'h0200, 1'b1, 2'd2, 32'h0);
        xreq("R6 invalid entry", 3, 16'h0001, 1'b0, 2'd3, 32'h0);
        xreq("R7 invalid beats all", 3, 16'h0500, 1'b1, 2'd3, 32'h0);

        twr(3, 32'hFFFF_FFF0, 15'h0040, 3'b110);
        xreq("R5 read write-only", 3, 16'h0005, 1'b0, 2'd2, 32'h0);
        xreq("R3 address wraps", 3, 16'h0020, 1'b1, 2'd0, 32'h0000_0010);

        // R10: write at the same edge as an accepted request.
        tw_en = 1'b1; tw_idx = 2'd1; tw_base = 32'h3000_0000; tw_len = 15'h0100; tw_perm = 3'b111;
        req_valid = 1'b1; req_vaddr = {2'd1, 14'h0010}; req_write = 1'b1;
        step();
        tw_en = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check("R10 same-edge write unseen", 32'(resp_cause), 32'd2);
        step();
        xreq("R10 write seen next", 1, 16'h0010, 1'b1, 2'd0, 32'h3000_0010);

        // R9: backpressure holds the response and blocks the next request.
        resp_ready = 1'b0;
        req_valid = 1'b1; req_vaddr = {2'd0, 14'h0007}; req_write = 1'b0;
        step();
        req_vaddr = {2'd2, 14'h0009};
        repeat (3) step();
        @(negedge clk);
        check("R9 held paddr", resp_paddr, 32'h1000_0007);
        check("R9 ready low", 32'(req_ready), 32'd0);
        step();
        resp_ready = 1'b1;
        step();
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 second after release", resp_paddr, 32'h2000_0009);
        step();

        // Randomized traffic with random backpressure and table writes.
        for (int k = 0; k < 600; k++) begin
            req_valid  = 1'($urandom_range(0, 1));
            req_write  = 1'($urandom_range(0, 1));
            req_vaddr  = 16'($urandom);
            resp_ready = ($urandom_range(0, 3) != 0);
            tw_en      = ($urandom_range(0, 9) == 0);
            tw_idx     = 2'($urandom);
            tw_base    = $urandom;
            tw_len     = 15'($urandom_range(0, 16384));
            tw_perm    = 3'($urandom);
            step();
        end
        req_valid = 1'b0; tw_en = 1'b0; resp_ready = 1'b1;
        repeat (3) step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule